// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer

This block issues one SD memory card command over a byte-wide SPI master port and returns the single-byte status the card answers with. A requester presents a 6-bit command index, a 32-bit argument and a flag marking the command as an application-specific one. The block frames the command into six bytes and sends each one through the SPI port. It then keeps clocking filler bytes until the card answers, and reports the answer together with a one-cycle completion pulse.

For application-specific commands, the block first sends the application prefix command (index 55, zero argument) on its own. It waits for that command's answer, ignores it, and then sends the requested command. Only the commands that a card checks before its checksum logic is switched off get a real checksum byte: the reset command (index 0) and the interface-condition command (index 8). Every other command carries a placeholder checksum byte. The block does not produce the serial clock and does not drive chip select. It exchanges one byte at a time through a start/done handshake with an external SPI engine.

The answer is found by polling, not read from a fixed byte position. The block accepts the first returned byte whose top bit is clear. If no such byte arrives within a bounded number of filler bytes, the last byte received is reported and a timeout flag is raised.

Top module: `sdcmd_framer`

## Requirements
- R1: The first byte sent for a command is 0x40 ORed with the 6-bit command index (bits 7:6 = 01).
- R2: Bytes two to five carry the 32-bit argument, most significant byte first.
- R3: The sixth byte is 0x95 when the index is 0, 0x87 when the index is 8, and 0x01 for every other index.
- R4: When req_app is set, the block first sends the six bytes 0x77 00 00 00 00 01 (index 55, zero argument) and polls for their answer, then sends the requested command.
- R5: After the six command bytes the block sends 0xFF fillers. The first returned byte with bit 7 = 0 is latched into rsp_status, rsp_done pulses high for exactly one cycle, and rsp_timeout is 0.
- R6: If POLL_MAX (default 255) fillers return bytes with bit 7 = 1, polling stops. rsp_status then holds the last byte received, and rsp_timeout = 1 is set with the rsp_done pulse.
- R7: A byte with bit 7 = 0 that arrives on the last allowed filler counts as a valid answer (rsp_timeout = 0, rsp_status = that byte).
- R8: spi_start is a one-cycle pulse, and no new spi_start is raised until spi_done has answered the previous one.
- R9: busy rises only in response to req_valid and stays high until the rsp_done pulse. A req_valid seen while busy is high changes neither the bytes sent nor the number of completions.
- R10: During and just after reset, busy, spi_start, rsp_done and rsp_timeout are 0 and rsp_status is 0x00.
- R11: The answer to the prefix command, including a prefix timeout, does not stop the requested command. rsp_status and rsp_timeout report only the requested command's answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while busy is low |
| req_index | input | 6 | Command index |
| req_app | input | 1 | Send the application prefix command first |
| req_arg | input | 32 | Command argument |
| busy | output | 1 | A request is in progress |
| rsp_status | output | 8 | Status byte of the last completed command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | No valid answer within the poll limit |
| spi_tx | output | 8 | Byte to send, valid while spi_start is high |
| spi_start | output | 1 | Start one SPI byte exchange |
| spi_rx | input | 8 | Byte received, valid while spi_done is high |
| spi_done | input | 1 | Exchange finished |

## Verification
Two decisions can fall on the same filler exchange: reaching the poll limit and receiving a valid answer. The bench provokes this by having the card model send its answer on exactly the 255th filler, and expects a clean status with no timeout. It also runs the neighbouring case, where every filler has its top bit set, and expects the final byte to be reported with the timeout flag. The prefix command meets the same boundary when it times out. In that case the bench checks that the requested command still goes out and that only its answer is reported.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int IDX_W       = 6;
    localparam int ARG_W       = 32;
    localparam int ARG_BYTES   = ARG_W / 8;
    localparam int FRAME_BYTES = ARG_BYTES + 2;
    localparam int SLOT_W      = $clog2(FRAME_BYTES + 1);
    localparam logic [SLOT_W-1:0] FILL_SLOT = SLOT_W'(FRAME_BYTES);

    localparam logic [IDX_W-1:0] IDX_RESET   = 6'd0;
    localparam logic [IDX_W-1:0] IDX_IFCOND  = 6'd8;
    localparam logic [IDX_W-1:0] IDX_PREFIX  = 6'd55;

    localparam logic [7:0] HEAD_BITS   = 8'h40;
    localparam logic [7:0] CHK_RESET   = 8'h95;
    localparam logic [7:0] CHK_IFCOND  = 8'h87;
    localparam logic [7:0] CHK_DUMMY   = 8'h01;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_e;

    typedef enum logic {
        PH_PREFIX = 1'b0,
        PH_MAIN   = 1'b1
    } phase_e;

    function automatic logic [7:0] chk_of(input logic [IDX_W-1:0] idx);
        logic [7:0] c;
        case (idx)
            IDX_RESET:  c = CHK_RESET;
            IDX_IFCOND: c = CHK_IFCOND;
            default:    c = CHK_DUMMY;
        endcase
        return c;
    endfunction

    function automatic cmd_t prefix_cmd();
        cmd_t c;
        c.idx = IDX_PREFIX;
        c.arg = '0;
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_byte_mux.sv
module sdcmd_byte_mux
    import sdcmd_pkg::*;
(
    input  cmd_t              cmd,
    input  logic [SLOT_W-1:0] slot,
    output logic [7:0]        tx_byte
);

    logic [7:0] frame [FRAME_BYTES];

    assign frame[0] = HEAD_BITS | {2'b00, cmd.idx};

    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
        assign frame[1+g] = cmd.arg[ARG_W-1-8*g -: 8];
    end

    assign frame[FRAME_BYTES-1] = chk_of(cmd.idx);

    always_comb begin
        tx_byte = FILL_BYTE;
        for (int k = 0; k < FRAME_BYTES; k++) begin
            if (slot == SLOT_W'(k)) tx_byte = frame[k];
        end
    end

endmodule

// File: rtl/sdcmd_poll.sv
module sdcmd_poll #(
    parameter int POLL_MAX = 255,
    localparam int CNT_W   = $clog2(POLL_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic rx_msb,
    output logic stop,
    output logic expired
);

    logic [CNT_W-1:0] count;
    logic             at_limit;

    assign at_limit = (count == CNT_W'(POLL_MAX - 1));
    assign stop     = sample && (!rx_msb || at_limit);
    assign expired  = sample && rx_msb && at_limit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (sample && !stop) begin
            count <= count + CNT_W'(1);
        end
    end

    // R6: the filler counter never runs past the poll limit
    a_r6_poll_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(POLL_MAX - 1));

    // R7: a valid answer byte never reports expiry
    a_r7_valid_not_expired: assert property (@(posedge clk) disable iff (rst)
        (sample && !rx_msb) |-> !expired);

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  cmd_t              req_cmd,
    input  logic              req_app,
    input  logic              spi_done,
    input  logic [7:0]        spi_rx,
    input  logic              stop,
    input  logic              expired,
    output cmd_t              cur_cmd,
    output logic [SLOT_W-1:0] slot,
    output logic              in_prefix,
    output logic              poll_clear,
    output logic              poll_sample,
    output logic              spi_start,
    output logic              busy,
    output logic [7:0]        rsp_status,
    output logic              rsp_done,
    output logic              rsp_timeout
);

    sq_state_e state;
    phase_e    phase;
    cmd_t      req_q;

    assign in_prefix   = (phase == PH_PREFIX);
    assign cur_cmd     = in_prefix ? prefix_cmd() : req_q;
    assign spi_start   = (state == SQ_ISSUE);
    assign busy        = (state != SQ_IDLE);
    assign poll_sample = (state == SQ_WAIT) && spi_done && (slot == FILL_SLOT);
    assign poll_clear  = ((state == SQ_IDLE) && req_valid) ||
                         (poll_sample && stop && in_prefix);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            phase       <= PH_MAIN;
            slot        <= '0;
            req_q       <= '0;
            rsp_status  <= 8'h00;
            rsp_timeout <= 1'b0;
            rsp_done    <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_cmd;
                        phase <= req_app ? PH_PREFIX : PH_MAIN;
                        slot  <= '0;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (spi_done) begin
                        if (slot != FILL_SLOT) begin
                            slot  <= slot + SLOT_W'(1);
                            state <= SQ_ISSUE;
                        end else if (stop) begin
                            if (in_prefix) begin
                                phase <= PH_MAIN;
                                slot  <= '0;
                                state <= SQ_ISSUE;
                            end else begin
                                rsp_status  <= spi_rx;
                                rsp_timeout <= expired;
                                rsp_done    <= 1'b1;
                                state       <= SQ_IDLE;
                            end
                        end else begin
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R8: one exchange at a time, start is a single-cycle pulse
    a_r8_start_pulse: assert property (@(posedge clk) disable iff (rst)
        spi_start |=> !spi_start);

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R9: busy only rises because a request arrived
    a_r9_busy_from_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R6: timeout flag only rises together with completion
    a_r6_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_timeout) |-> rsp_done);

    // R7: a non-timeout completion carries a status with bit 7 clear
    a_r7_status_valid: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_timeout) |-> !rsp_status[7]);

    // R10: outputs idle right after reset
    a_r10_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !rsp_done && !rsp_timeout && rsp_status == 8'h00));

endmodule

// File: rtl/sdcmd_framer.sv
module sdcmd_framer
    import sdcmd_pkg::*;
#(
    parameter int POLL_MAX = 255
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [5:0]  req_index,
    input  logic        req_app,
    input  logic [31:0] req_arg,
    output logic        busy,
    output logic [7:0]  rsp_status,
    output logic        rsp_done,
    output logic        rsp_timeout,
    output logic [7:0]  spi_tx,
    output logic        spi_start,
    input  logic [7:0]  spi_rx,
    input  logic        spi_done
);

    cmd_t              req_cmd;
    cmd_t              cur_cmd;
    logic [SLOT_W-1:0] slot;
    logic              in_prefix;
    logic              poll_clear;
    logic              poll_sample;
    logic              stop;
    logic              expired;

    assign req_cmd.idx = req_index;
    assign req_cmd.arg = req_arg;

    sdcmd_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_app     (req_app),
        .spi_done    (spi_done),
        .spi_rx      (spi_rx),
        .stop        (stop),
        .expired     (expired),
        .cur_cmd     (cur_cmd),
        .slot        (slot),
        .in_prefix   (in_prefix),
        .poll_clear  (poll_clear),
        .poll_sample (poll_sample),
        .spi_start   (spi_start),
        .busy        (busy),
        .rsp_status  (rsp_status),
        .rsp_done    (rsp_done),
        .rsp_timeout (rsp_timeout)
    );

    sdcmd_poll #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .clear   (poll_clear),
        .sample  (poll_sample),
        .rx_msb  (spi_rx[7]),
        .stop    (stop),
        .expired (expired)
    );

    sdcmd_byte_mux u_mux (
        .cmd     (cur_cmd),
        .slot    (slot),
        .tx_byte (spi_tx)
    );

    // R1: every frame opens with bits 7:6 = 01
    a_r1_head_bits: assert property (@(posedge clk) disable iff (rst)
        (spi_start && slot == '0) |-> (spi_tx[7:6] == 2'b01));

    // R3: the reset command carries its fixed checksum byte
    a_r3_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_start && slot == SLOT_W'(FRAME_BYTES-1) && cur_cmd.idx == IDX_RESET)
            |-> (spi_tx == 8'h95));

    // R4: the prefix frame opens with index 55
    a_r4_prefix_head: assert property (@(posedge clk) disable iff (rst)
        (spi_start && in_prefix && slot == '0) |-> (spi_tx == 8'h77));

    // R5: fillers are all-ones
    a_r5_filler: assert property (@(posedge clk) disable iff (rst)
        (spi_start && slot == FILL_SLOT) |-> (spi_tx == 8'hFF));

endmodule

// File: tb/sim_sdcmd_framer.sv
`timescale 1ns/1ps
module sim_sdcmd_framer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_index = '0;
    logic        req_app = 1'b0;
    logic [31:0] req_arg = '0;
    logic        busy, rsp_done, rsp_timeout, spi_start;
    logic [7:0]  rsp_status, spi_tx;
    logic [7:0]  spi_rx = 8'hFF;
    logic        spi_done = 1'b0;

    always #2 clk = ~clk;

    sdcmd_framer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_app(req_app), .req_arg(req_arg), .busy(busy),
        .rsp_status(rsp_status), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
        .spi_tx(spi_tx), .spi_start(spi_start), .spi_rx(spi_rx), .spi_done(spi_done)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic        app;
        logic [31:0] arg;
        logic [8:0]  pw;   // prefix answer position (0 = never)
        logic [7:0]  pr;
        logic [8:0]  mw;   // main answer position (0 = never)
        logic [7:0]  mr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{6'd0,  1'b0, 32'h0000_0000, 9'd0, 8'h00, 9'd1,   8'h01},
        '{6'd8,  1'b0, 32'h0000_01AA, 9'd0, 8'h00, 9'd3,   8'h05},
        '{6'd17, 1'b0, 32'h1234_5678, 9'd0, 8'h00, 9'd2,   8'h00},
        '{6'd41, 1'b1, 32'h4000_0000, 9'd1, 8'h01, 9'd4,   8'h00},
        '{6'd58, 1'b0, 32'hA5C3_0F96, 9'd0, 8'h00, 9'd7,   8'h7F},
        '{6'd63, 1'b0, 32'hFFFF_FFFF, 9'd0, 8'h00, 9'd255, 8'h00},
        '{6'd12, 1'b0, 32'h0000_0000, 9'd0, 8'h00, 9'd0,   8'h00},
        '{6'd13, 1'b1, 32'h0BAD_F00D, 9'd0, 8'h00, 9'd1,   8'h04}
    };

    int total = 0;
    int bad   = 0;

    // card model state
    logic [8:0] wn [2];
    logic [7:0] rv [2];
    logic [7:0] txlog [1200];
    int txn = 0, cmdno = 0, cnt = 0, lat = 1, viol = 0;

    function automatic logic [7:0] junk(int f);
        return 8'h80 | {1'b0, 7'(f + 3)};
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            spi_done = 1'b0;
            if (spi_start) begin
                logic [7:0] r;
                logic       edge_hit;
                int         f;
                if (txn < 1200) txlog[txn] = spi_tx;
                txn++;
                edge_hit = 1'b0;
                if (cnt < 6) begin
                    r = 8'hFF;
                end else begin
                    f = cnt - 5;
                    if (wn[cmdno] != 0 && f == int'(wn[cmdno])) begin
                        r = rv[cmdno]; edge_hit = 1'b1;
                    end else begin
                        r = junk(f);
                        if (f == 255) edge_hit = 1'b1;
                    end
                end
                if (edge_hit) begin cnt = 0; cmdno++; end
                else cnt++;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    if (spi_start) viol++;
                end
                spi_rx   = r;
                spi_done = 1'b1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exb(logic [5:0] idx, logic [31:0] arg, int k);
        case (k)
            0: return 8'h40 | {2'b00, idx};
            1: return arg[31:24];
            2: return arg[23:16];
            3: return arg[15:8];
            4: return arg[7:0];
            5: return (idx == 6'd0) ? 8'h95 : (idx == 6'd8) ? 8'h87 : 8'h01;
            default: return 8'hFF;
        endcase
    endfunction

    // compare one frame plus fillers; returns next log position
    task automatic chk_frame(string tag, logic [5:0] idx, logic [31:0] arg,
                             int pos, int fills, output int nxt);
        int mism = 0, first = -1;
        logic [7:0] a = 8'h00, e = 8'h00;
        for (int k = 0; k < 6 + fills; k++) begin
            if (pos + k >= 1200 || txlog[pos+k] !== exb(idx, arg, k)) begin
                if (first < 0) begin
                    first = k;
                    a = (pos + k < 1200) ? txlog[pos+k] : 8'hXX;
                    e = exb(idx, arg, k);
                end
                mism++;
            end
        end
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s: byte %0d actual=%h expected=%h", tag, first, a, e);
        end
        nxt = pos + 6 + fills;
    endtask

    task automatic wait_done(output logic got);
        got = 1'b0;
        for (int c = 0; c < 20000 && !got; c++) begin
            @(negedge clk);
            if (rsp_done) got = 1'b1;
        end
    endtask

    task automatic run_vec(int i);
        vec_t v;
        logic got;
        int pos, pf, mf;
        v = VEC[i];
        wn[0] = v.pw; rv[0] = v.pr; wn[1] = v.mw; rv[1] = v.mr;
        cmdno = v.app ? 0 : 1; cnt = 0; txn = 0; lat = 1 + (i % 3);
        @(negedge clk);
        req_valid = 1'b1; req_index = v.idx; req_app = v.app; req_arg = v.arg;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after request", 32'(busy), 32'd1);
        wait_done(got);
        chk("R5 done seen", 32'(got), 32'd1);
        pf = (v.pw == 0) ? 255 : int'(v.pw);
        mf = (v.mw == 0) ? 255 : int'(v.mw);
        pos = 0;
        if (v.app) chk_frame("R4 prefix frame", 6'd55, 32'h0, pos, pf, pos);
        // R1 R2 R3 frame bytes, R5 fillers
        chk_frame("R1 R2 R3 command frame", v.idx, v.arg, pos, mf, pos);
        chk("R8 exchange count", 32'(txn), 32'(pos));
        if (v.mw == 0) begin
            chk("R6 status is last byte", 32'(rsp_status), 32'(junk(255)));
            chk("R6 timeout flag", 32'(rsp_timeout), 32'd1);
        end else begin
            chk(v.mw == 255 ? "R7 status on last filler" : "R5 status",
                32'(rsp_status), 32'(v.mr));
            chk(v.app ? "R11 timeout from main only" : "R5 timeout low",
                32'(rsp_timeout), 32'd0);
        end
        @(negedge clk);
        chk("R5 done single pulse", 32'(rsp_done), 32'd0);
        chk("R9 busy low after done", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic got;
        int pos, extra;
        wn[0] = 0; wn[1] = 0; rv[0] = 0; rv[1] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 spi_start", 32'(spi_start), 32'd0);
        chk("R10 rsp_done", 32'(rsp_done), 32'd0);
        chk("R10 rsp_timeout", 32'(rsp_timeout), 32'd0);
        chk("R10 rsp_status", 32'(rsp_status), 32'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 idle after release", 32'(busy), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: a second request while busy is ignored
        wn[1] = 9'd3; rv[1] = 8'h00; cmdno = 1; cnt = 0; txn = 0; lat = 2;
        @(negedge clk);
        req_valid = 1'b1; req_index = 6'd17; req_app = 1'b0; req_arg = 32'h0000_0200;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_index = 6'd24; req_app = 1'b1; req_arg = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0; req_index = 6'd0; req_app = 1'b0; req_arg = 32'h0;
        wait_done(got);
        chk("R9 done for first request", 32'(got), 32'd1);
        pos = 0;
        chk_frame("R9 frame unaffected", 6'd17, 32'h0000_0200, pos, 3, pos);
        chk("R9 exchange count", 32'(txn), 32'(pos));
        extra = 0;
        repeat (200) begin
            @(negedge clk);
            if (rsp_done) extra++;
        end
        chk("R9 no second completion", 32'(extra), 32'd0);
        chk("R8 no overlapped start", 32'(viol), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule